// File: doc/BRIEF.md
# Trap-level state stack unit

This block keeps the per-level saved machine state for a processor that allows traps to nest. When a trap is taken, the core presents its current program counter, next program counter, condition codes, address-space identifier, processor-state field and window pointer. The unit packs the four small fields into one word and stores that word, both counters and the trap type in the slot for the current trap level. It then reports the processor state to force, the vector address to jump to and the new level. Each entry completes in one cycle.

On a return the unit reads the slot of the level being left and hands the restored fields back to the core. A retry resumes at the saved counter pair. A done resumes one instruction later, taking the saved next counter as the program counter. The level then drops by one. A trap taken at the top level is reported as a fault and changes nothing. All results appear on registered outputs one clock after the request, flagged by `out_valid` and an event code.

Top module: `trap_stack_unit`

## Requirements
- R1: After reset `tl` is 0 and `out_valid` is 0.
- R2: An accepted entry stores a packed word with the window pointer at bit 0, the 12-bit processor state at bit 8, the address-space identifier at bit 24 and the condition codes from bit 32, together with PC, next PC and trap type, in the slot indexed by the level before entry. A later return from that level gives all of them back unchanged, and the trap type appears on `out_tt`.
- R3: Event codes on `out_event` are 1 = trap entry, 2 = retry, 3 = done, 4 = fault. On an entry below level MAX_TL-1, `out_pstate` is 0x015: FP-enable at bit 4, privileged at bit 2, alternate globals at bit 0.
- R4: The entry vector on `out_pc` keeps `tba_base` above bit 14. Bits 13:5 hold the trap type, bit 14 is set only when the level before entry is above 1, and bits 4:0 are zero. `out_npc` is the vector plus 4.
- R5: An entry taken below level MAX_TL-1 increments `tl` by one.
- R6: An entry taken at level MAX_TL-1 also sets the red-state bit (bit 5, giving 0x035) and moves `tl` to MAX_TL.
- R7: A trap request at level MAX_TL reports the fault event, keeps `tl` and stores nothing. Later returns still restore the earlier levels' contents.
- R8: Retry restores PC from the saved PC and next PC from the saved next PC.
- R9: Done restores PC from the saved next PC and sets next PC to that value plus 4.
- R10: A return requested at level 0 is ignored: `out_valid` stays 0 and `tl` stays 0.
- R11: When a trap and a return are requested in the same cycle, only the trap is acted on.
- R12: A return decrements `tl` and reads the slot of the level being left, so nested entries unwind last-in first-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Trap entry request, one cycle |
| trap_type | input | TT_W | Trap type of the entry |
| ret_req | input | 1 | Return request, one cycle |
| ret_done | input | 1 | 1 = done form, 0 = retry form |
| tba_base | input | PC_W-15 | Upper bits of the trap base |
| cur_pc | input | PC_W | Current program counter |
| cur_npc | input | PC_W | Current next program counter |
| cur_ccr | input | CCR_W | Current condition codes |
| cur_asi | input | 8 | Current address-space identifier |
| cur_pstate | input | 12 | Current processor state |
| cur_cwp | input | 8 | Current window pointer |
| out_valid | output | 1 | Result valid this cycle |
| out_event | output | 3 | Event code of the result |
| out_pc | output | PC_W | Vector or restored program counter |
| out_npc | output | PC_W | Next program counter to use |
| out_ccr | output | CCR_W | Restored condition codes |
| out_asi | output | 8 | Restored address-space identifier |
| out_pstate | output | 12 | Forced or restored processor state |
| out_cwp | output | 8 | Restored window pointer |
| out_tt | output | TT_W | Trap type of the entry or of the level left |
| tl | output | $clog2(MAX_TL+1) | Current trap level |

## Verification
The hardest conditions to reach are the top of the stack: the red-state entry at level MAX_TL-1 and the fault at MAX_TL. Both need a run of nested entries with no return between them. The stimulus climbs to the top with a distinct trap type and counter pair at every level. It then requests further traps, one of them in the same cycle as a return. After that it unwinds in mixed retry and done form, so every slot is read back after the refused entries. A final return at level 0 checks that the empty stack ignores it.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
   // event codes reported on out_event
   localparam logic [2:0] EV_NONE  = 3'd0;
   localparam logic [2:0] EV_TRAP  = 3'd1;
   localparam logic [2:0] EV_RETRY = 3'd2;
   localparam logic [2:0] EV_DONE  = 3'd3;
   localparam logic [2:0] EV_FAULT = 3'd4;

   // processor-state bit positions
   localparam int PS_W       = 12;
   localparam int PS_AG_BIT  = 0;
   localparam int PS_PRIV_BIT = 2;
   localparam int PS_PEF_BIT = 4;
   localparam int PS_RED_BIT = 5;

   // packed state word layout
   localparam int CWP_LSB = 0;
   localparam int CWP_W   = 8;
   localparam int PSF_LSB = 8;
   localparam int ASI_LSB = 24;
   localparam int ASI_W   = 8;
   localparam int CCR_LSB = 32;

   // low trap-base field
   localparam int VEC_LOW_W  = 15;
   localparam int VEC_TT_LSB = 5;
   localparam int VEC_NEST_BIT = 14;
endpackage

// File: rtl/tsu_level_ctr.sv
module tsu_level_ctr #(
   parameter int MAX_TL = 5,
   parameter int LVL_W  = $clog2(MAX_TL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [LVL_W-1:0] lvl
);
   logic [LVL_W-1:0] lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lvl_q <= '0;
      else if (inc && !dec)
         lvl_q <= lvl_q + LVL_W'(1);
      else if (dec && !inc)
         lvl_q <= lvl_q - LVL_W'(1);
   end

   assign lvl = lvl_q;

   assert_lvl_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q <= LVL_W'(MAX_TL));
   assert_inc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec) |=> lvl_q == $past(lvl_q) + LVL_W'(1));
   assert_dec_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc) |=> lvl_q == $past(lvl_q) - LVL_W'(1));
   assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> lvl_q != '0);
endmodule

// File: rtl/tsu_frame_store.sv
module tsu_frame_store #(
   parameter int DEPTH = 5,
   parameter int FR_W  = 64,
   parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [FR_W-1:0]  wr_frame,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [FR_W-1:0]  rd_frame
);
   logic [FR_W-1:0] slots [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [FR_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (we && wr_idx == IDX_W'(i))
            q <= wr_frame;
      end
      assign slots[i] = q;
   end

   always_comb begin
      rd_frame = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_idx == IDX_W'(i))
            rd_frame = slots[i];
      end
   end

   assert_wr_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> int'(wr_idx) < DEPTH);
endmodule

// File: rtl/tsu_vector_gen.sv
module tsu_vector_gen
   import tsu_pkg::*;
#(
   parameter int PC_W   = 64,
   parameter int TT_W   = 9,
   parameter int MAX_TL = 5,
   parameter int LVL_W  = $clog2(MAX_TL + 1)
) (
   input  logic [PC_W-VEC_LOW_W-1:0] tba_base,
   input  logic [TT_W-1:0]           tt,
   input  logic [LVL_W-1:0]          lvl,
   output logic [PC_W-1:0]           vec,
   output logic [PS_W-1:0]           entry_ps
);
   logic [VEC_LOW_W-1:0] low;

   always_comb begin
      low = '0;
      low[VEC_TT_LSB +: TT_W] = tt;
      low[VEC_NEST_BIT] = (lvl > LVL_W'(1));
      vec = {tba_base, low};
   end

   always_comb begin
      entry_ps = '0;
      entry_ps[PS_PEF_BIT]  = 1'b1;
      entry_ps[PS_PRIV_BIT] = 1'b1;
      entry_ps[PS_AG_BIT]   = 1'b1;
      entry_ps[PS_RED_BIT]  = (lvl >= LVL_W'(MAX_TL - 1));
   end
endmodule

// File: rtl/trap_stack_unit.sv
module trap_stack_unit
   import tsu_pkg::*;
#(
   parameter int PC_W   = 64,
   parameter int MAX_TL = 5,
   parameter int TT_W   = 9,
   parameter int CCR_W  = 8,
   localparam int LVL_W = $clog2(MAX_TL + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      trap_req,
   input  logic [TT_W-1:0]           trap_type,
   input  logic                      ret_req,
   input  logic                      ret_done,
   input  logic [PC_W-VEC_LOW_W-1:0] tba_base,
   input  logic [PC_W-1:0]           cur_pc,
   input  logic [PC_W-1:0]           cur_npc,
   input  logic [CCR_W-1:0]          cur_ccr,
   input  logic [ASI_W-1:0]          cur_asi,
   input  logic [PS_W-1:0]           cur_pstate,
   input  logic [CWP_W-1:0]          cur_cwp,
   output logic                      out_valid,
   output logic [2:0]                out_event,
   output logic [PC_W-1:0]           out_pc,
   output logic [PC_W-1:0]           out_npc,
   output logic [CCR_W-1:0]          out_ccr,
   output logic [ASI_W-1:0]          out_asi,
   output logic [PS_W-1:0]           out_pstate,
   output logic [CWP_W-1:0]          out_cwp,
   output logic [TT_W-1:0]           out_tt,
   output logic [LVL_W-1:0]          tl
);
   localparam int WORD_W = CCR_LSB + CCR_W;
   localparam int FR_W   = WORD_W + 2 * PC_W + TT_W;
   localparam int IDX_W  = $clog2(MAX_TL);
   localparam int RSV_W  = ASI_LSB - (PSF_LSB + PS_W);

   // elaboration checks on the parameter set
   if (MAX_TL < 2) begin : g_bad_depth
      $error("trap_stack_unit: MAX_TL must be at least 2");
   end
   if (TT_W > VEC_NEST_BIT - VEC_TT_LSB) begin : g_bad_tt
      $error("trap_stack_unit: TT_W does not fit below the nesting bit");
   end
   if (PC_W < VEC_LOW_W + 1) begin : g_bad_pc
      $error("trap_stack_unit: PC_W too small for the trap base");
   end

   logic [LVL_W-1:0] lvl;
   logic             at_top;
   logic             trap_ok;
   logic             trap_fault;
   logic             ret_ok;
   logic [WORD_W-1:0] wr_word;
   logic [FR_W-1:0]   wr_frame;
   logic [FR_W-1:0]   rd_frame;
   logic [WORD_W-1:0] rd_word;
   logic [PC_W-1:0]   rd_pc;
   logic [PC_W-1:0]   rd_npc;
   logic [TT_W-1:0]   rd_tt;
   logic [PC_W-1:0]   vec;
   logic [PS_W-1:0]   entry_ps;

   // request decode: a trap always wins over a return
   assign at_top     = (lvl == LVL_W'(MAX_TL));
   assign trap_ok    = trap_req && !at_top;
   assign trap_fault = trap_req && at_top;
   assign ret_ok     = ret_req && !trap_req && (lvl != '0);

   // state word packing
   always_comb begin
      wr_word = '0;
      wr_word[CWP_LSB +: CWP_W] = cur_cwp;
      wr_word[PSF_LSB +: PS_W]  = cur_pstate;
      wr_word[ASI_LSB +: ASI_W] = cur_asi;
      wr_word[CCR_LSB +: CCR_W] = cur_ccr;
   end
   assign wr_frame = {wr_word, cur_pc, cur_npc, trap_type};
   assign {rd_word, rd_pc, rd_npc, rd_tt} = rd_frame;

   tsu_level_ctr #(.MAX_TL(MAX_TL), .LVL_W(LVL_W)) u_level (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (trap_ok),
      .dec  (ret_ok),
      .lvl  (lvl)
   );

   tsu_frame_store #(.DEPTH(MAX_TL), .FR_W(FR_W), .IDX_W(IDX_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (trap_ok),
      .wr_idx  (IDX_W'(lvl)),
      .wr_frame(wr_frame),
      .rd_idx  (IDX_W'(lvl - LVL_W'(1))),
      .rd_frame(rd_frame)
   );

   tsu_vector_gen #(.PC_W(PC_W), .TT_W(TT_W), .MAX_TL(MAX_TL), .LVL_W(LVL_W)) u_vec (
      .tba_base(tba_base),
      .tt      (trap_type),
      .lvl     (lvl),
      .vec     (vec),
      .entry_ps(entry_ps)
   );

   // registered result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_event  <= EV_NONE;
         out_pc     <= '0;
         out_npc    <= '0;
         out_ccr    <= '0;
         out_asi    <= '0;
         out_pstate <= '0;
         out_cwp    <= '0;
         out_tt     <= '0;
      end else begin
         out_valid  <= trap_req || ret_ok;
         out_event  <= EV_NONE;
         out_pc     <= '0;
         out_npc    <= '0;
         out_ccr    <= '0;
         out_asi    <= '0;
         out_pstate <= '0;
         out_cwp    <= '0;
         out_tt     <= '0;
         if (trap_fault) begin
            out_event <= EV_FAULT;
            out_tt    <= trap_type;
         end else if (trap_ok) begin
            out_event  <= EV_TRAP;
            out_pc     <= vec;
            out_npc    <= vec + PC_W'(4);
            out_pstate <= entry_ps;
            out_tt     <= trap_type;
         end else if (ret_ok) begin
            out_event  <= ret_done ? EV_DONE : EV_RETRY;
            out_pc     <= ret_done ? rd_npc : rd_pc;
            out_npc    <= ret_done ? rd_npc + PC_W'(4) : rd_npc;
            out_ccr    <= rd_word[CCR_LSB +: CCR_W];
            out_asi    <= rd_word[ASI_LSB +: ASI_W];
            out_pstate <= rd_word[PSF_LSB +: PS_W];
            out_cwp    <= rd_word[CWP_LSB +: CWP_W];
            out_tt     <= rd_tt;
         end
      end
   end

   assign tl = lvl;

   // checks next to the logic they guard
   assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ret_ok |-> rd_word[PSF_LSB + PS_W +: RSV_W] == '0);
   assert_entry_priv_R3: assert property (@(posedge clk) disable iff (!rst_n)
      trap_ok |=> out_pstate[PS_PRIV_BIT] && out_pstate[PS_PEF_BIT] && out_pstate[PS_AG_BIT]);
   assert_vec_npc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_event == EV_TRAP) |-> out_npc == out_pc + PC_W'(4));
   assert_red_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_ok && lvl == LVL_W'(MAX_TL - 1)) |=> out_pstate[PS_RED_BIT] && tl == LVL_W'(MAX_TL));
   assert_fault_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && tl == LVL_W'(MAX_TL)) |=> out_event == EV_FAULT && $stable(tl));
   assert_done_npc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_event == EV_DONE) |-> out_npc == out_pc + PC_W'(4));
   assert_ret_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req && !trap_req && tl == '0) |=> !out_valid && tl == '0);
   assert_trap_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && ret_req) |=> out_event == EV_TRAP || out_event == EV_FAULT);
   assert_one_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == (out_event != EV_NONE));
endmodule

// File: tb/trap_stack_unit_test.sv
module trap_stack_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int PC_W = 64;
   localparam int MAX_TL = 5;
   localparam int TT_W = 9;
   localparam int LVL_W = $clog2(MAX_TL + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trap_req = 1'b0;
   logic [TT_W-1:0] trap_type = '0;
   logic ret_req = 1'b0;
   logic ret_done = 1'b0;
   logic [PC_W-16:0] tba_base = 49'h0_DEAD_BEEF_1234;
   logic [PC_W-1:0] cur_pc = '0;
   logic [PC_W-1:0] cur_npc = '0;
   logic [7:0] cur_ccr = '0;
   logic [7:0] cur_asi = '0;
   logic [11:0] cur_pstate = '0;
   logic [7:0] cur_cwp = '0;
   logic out_valid;
   logic [2:0] out_event;
   logic [PC_W-1:0] out_pc, out_npc;
   logic [7:0] out_ccr, out_asi, out_cwp;
   logic [11:0] out_pstate;
   logic [TT_W-1:0] out_tt;
   logic [LVL_W-1:0] tl;

   trap_stack_unit #(.PC_W(PC_W), .MAX_TL(MAX_TL), .TT_W(TT_W), .CCR_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
      .ret_req(ret_req), .ret_done(ret_done), .tba_base(tba_base),
      .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_ccr(cur_ccr), .cur_asi(cur_asi),
      .cur_pstate(cur_pstate), .cur_cwp(cur_cwp), .out_valid(out_valid),
      .out_event(out_event), .out_pc(out_pc), .out_npc(out_npc), .out_ccr(out_ccr),
      .out_asi(out_asi), .out_pstate(out_pstate), .out_cwp(out_cwp),
      .out_tt(out_tt), .tl(tl));

   always #(CLK_PERIOD / 2) clk = ~clk;

   typedef struct {
      int unsigned due;
      string req;
      bit valid;
      logic [2:0] ev;
      logic [PC_W-1:0] pc, npc;
      logic [7:0] ccr, asi, cwp;
      logic [11:0] ps;
      logic [TT_W-1:0] tt;
      logic [LVL_W-1:0] lvl;
   } exp_t;

   exp_t q[$];
   int errors = 0;
   int checks = 0;
   int unsigned cyc = 0;
   bit done_run = 0;

   // reference model state
   int mtl = 0;
   logic [PC_W-1:0] m_pc [MAX_TL];
   logic [PC_W-1:0] m_npc [MAX_TL];
   logic [7:0] m_ccr [MAX_TL], m_asi [MAX_TL], m_cwp [MAX_TL];
   logic [11:0] m_ps [MAX_TL];
   logic [TT_W-1:0] m_tt [MAX_TL];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic fail(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
   endtask

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) fail(req, what, act, exp);
   endtask

   // monitor: compare results against the scoreboard
   always @(negedge clk) begin
      if (rst_n && !done_run) begin
         if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            chk(e.req, "valid", 64'(out_valid), 64'(e.valid));
            chk(e.req, "tl", 64'(tl), 64'(e.lvl));
            if (e.valid) begin
               chk(e.req, "event", 64'(out_event), 64'(e.ev));
               chk(e.req, "tt", 64'(out_tt), 64'(e.tt));
               if (e.ev != 3'd4) begin
                  chk(e.req, "pc", out_pc, e.pc);
                  chk(e.req, "npc", out_npc, e.npc);
                  chk(e.req, "pstate", 64'(out_pstate), 64'(e.ps));
               end
               if (e.ev == 3'd2 || e.ev == 3'd3) begin
                  chk(e.req, "ccr", 64'(out_ccr), 64'(e.ccr));
                  chk(e.req, "asi", 64'(out_asi), 64'(e.asi));
                  chk(e.req, "cwp", 64'(out_cwp), 64'(e.cwp));
               end
            end
         end else if (out_valid) begin
            checks++;
            fail("R10", "unexpected result", 64'(out_event), 64'd0);
         end
      end
   end

   // driver: one request per cycle, expected item pushed to the queue
   task automatic op(input string req, input bit trp, input bit rt, input bit dn,
                     input logic [TT_W-1:0] tt, input logic [PC_W-1:0] pc,
                     input logic [PC_W-1:0] npc, input logic [7:0] ccr,
                     input logic [7:0] asi, input logic [11:0] ps, input logic [7:0] cwp);
      exp_t e;
      @(posedge clk);
      #1;
      trap_req = trp; ret_req = rt; ret_done = dn; trap_type = tt;
      cur_pc = pc; cur_npc = npc; cur_ccr = ccr; cur_asi = asi;
      cur_pstate = ps; cur_cwp = cwp;
      e = '{due: cyc + 1, req: req, valid: 0, ev: 3'd0, pc: '0, npc: '0,
            ccr: '0, asi: '0, cwp: '0, ps: '0, tt: '0, lvl: '0};
      if (trp) begin
         e.valid = 1;
         e.tt = tt;
         if (mtl == MAX_TL) begin
            e.ev = 3'd4;
         end else begin
            e.ev = 3'd1;
            e.pc = {tba_base, (mtl > 1) ? 1'b1 : 1'b0, tt, 5'b0};
            e.npc = e.pc + 64'd4;
            e.ps = (mtl >= MAX_TL - 1) ? 12'h035 : 12'h015;
            m_pc[mtl] = pc; m_npc[mtl] = npc; m_ccr[mtl] = ccr;
            m_asi[mtl] = asi; m_ps[mtl] = ps; m_cwp[mtl] = cwp; m_tt[mtl] = tt;
            mtl++;
         end
      end else if (rt && mtl > 0) begin
         mtl--;
         e.valid = 1;
         e.ev = dn ? 3'd3 : 3'd2;
         e.pc = dn ? m_npc[mtl] : m_pc[mtl];
         e.npc = dn ? m_npc[mtl] + 64'd4 : m_npc[mtl];
         e.ccr = m_ccr[mtl]; e.asi = m_asi[mtl]; e.ps = m_ps[mtl];
         e.cwp = m_cwp[mtl]; e.tt = m_tt[mtl];
      end
      e.lvl = LVL_W'(mtl);
      q.push_back(e);
   endtask

   task automatic idle();
      @(posedge clk);
      #1;
      trap_req = 0; ret_req = 0;
   endtask

   initial begin
      fork
         begin
            repeat (3) @(posedge clk);
            #1 rst_n = 1'b1;
            @(negedge clk);
            chk("R1", "reset valid", 64'(out_valid), 64'd0);
            chk("R1", "reset tl", 64'(tl), 64'd0);
            // R10: return on an empty stack
            op("R10", 0, 1, 1, 9'h000, 64'h0, 64'h0, 8'h0, 8'h0, 12'h0, 8'h0);
            // R3 R4 R5: nested entries with distinct contents (R2)
            op("R4", 1, 0, 0, 9'h041, 64'h1000, 64'h1004, 8'hA5, 8'h80, 12'h816, 8'h03);
            op("R4", 1, 0, 0, 9'h1FF, 64'h2000, 64'h2004, 8'h5A, 8'h04, 12'h0C3, 8'h07);
            op("R5", 1, 0, 0, 9'h022, 64'h3000, 64'h3008, 8'h11, 8'h10, 12'h7FF, 8'h01);
            op("R5", 1, 0, 0, 9'h100, 64'hFFFF_FFFF_FFFF_FFF0, 64'h4000, 8'hFF, 8'h19, 12'h001, 8'h00);
            // R6: entry at MAX_TL-1
            op("R6", 1, 0, 0, 9'h0AA, 64'h5000, 64'h5004, 8'h3C, 8'h88, 12'hABC, 8'hFF);
            // R7: traps at the top, R11: together with a return
            op("R7", 1, 0, 0, 9'h033, 64'h6000, 64'h6004, 8'h77, 8'h77, 12'h777, 8'h77);
            op("R11", 1, 1, 1, 9'h044, 64'h7000, 64'h7004, 8'h66, 8'h66, 12'h666, 8'h66);
            // R12 R8 R9: unwind in mixed form
            op("R9", 0, 1, 1, 9'h0, 64'h0, 64'h0, 8'h0, 8'h0, 12'h0, 8'h0);
            op("R8", 0, 1, 0, 9'h0, 64'h0, 64'h0, 8'h0, 8'h0, 12'h0, 8'h0);
            op("R12", 0, 1, 1, 9'h0, 64'h0, 64'h0, 8'h0, 8'h0, 12'h0, 8'h0);
            // R11 below the top: trap wins, level rises
            op("R11", 1, 1, 0, 9'h155, 64'h8000, 64'h8010, 8'h42, 8'h24, 12'h555, 8'h05);
            op("R8", 0, 1, 0, 9'h0, 64'h0, 64'h0, 8'h0, 8'h0, 12'h0, 8'h0);
            op("R2", 0, 1, 0, 9'h0, 64'h0, 64'h0, 8'h0, 8'h0, 12'h0, 8'h0);
            op("R9", 0, 1, 1, 9'h0, 64'h0, 64'h0, 8'h0, 8'h0, 12'h0, 8'h0);
            op("R10", 0, 1, 0, 9'h0, 64'h0, 64'h0, 8'h0, 8'h0, 12'h0, 8'h0);
            // R3: fresh entry from level 0 after full unwind
            op("R3", 1, 0, 0, 9'h0FE, 64'h9000, 64'h9004, 8'h01, 8'h02, 12'h003, 8'h04);
            op("R8", 0, 1, 0, 9'h0, 64'h0, 64'h0, 8'h0, 8'h0, 12'h0, 8'h0);
            idle();
            repeat (4) @(posedge clk);
            if (q.size() != 0) begin
               checks++;
               fail("R12", "results missing", 64'(q.size()), 64'd0);
            end
         end
         begin
            repeat (2000) @(posedge clk);
            checks++;
            fail("R1", "watchdog expired", 64'(cyc), 64'd0);
         end
      join_any
      disable fork;
      done_run = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule